// File: doc/BRIEF.md
# Byte-Pair Transfer and Index Arithmetic Unit

This unit carries out the byte-wide instructions of a nibble-oriented processor core. The core's accumulator pair is treated as one byte (B is the high nibble, A the low nibble, written BA). The unit moves that byte to and from either half of the two 16-bit index registers X and Y, an 8-bit extension register, and two stack pointers. It also adds a byte (unsigned BA or a signed immediate) to an index register, compares the low byte of an index register with an immediate, and steps a stack pointer up or down. Flags C, Z and E are kept here.

Memory holds one nibble per address. A byte sits in two consecutive addresses with the low nibble first. Byte loads and stores through an index register take two cycles: the low nibble moves at the index address, the high nibble at the index address plus one, and the index then advances by two. The memory port reads asynchronously: `mem_rdata` must reflect `mem_addr` in the same cycle. The issuer presents one 13-bit word with `instr_valid`. While `busy` is high the unit finishes the second half of a memory transfer and ignores its instruction inputs.

Top module: `byte_xfer_unit`

## Requirements
- R1: While `rst_n` is low and after its release, A, B, X, Y, EXT, both stack pointers, C, Z, E and `busy` are zero, and neither `mem_rd` nor `mem_we` is asserted.
- R2: Words with bits 12..6 = 1111111 select a register move by bits 5..0, taking effect at the next clock edge. Moves into BA are 0010hh (hh: 00 XL, 01 XH, 10 YL, 11 YH), 00110x (SP1), 00111x (SP2) and 01011x (EXT). Moves from BA are 0000hh (same hh coding), 00010x (SP1), 00011x (SP2) and 01010x (EXT). A stack pointer loaded from BA takes the byte zero-extended, and BA reads the low byte of a stack pointer.
- R3: Bits 12..8 select an immediate load of bits 7..0: 01001 into BA (A gets bits 3..0, B bits 7..4), 01010 into the low byte of X, 01011 into the low byte of Y, 01000 into EXT.
- R4: Sub-codes 011000 (through X) and 011010 (through Y) load BA from memory: in the first cycle `mem_rd` is high with `mem_addr` equal to the index and A takes `mem_rdata`. In the second cycle `mem_addr` is the index plus one (modulo 2^16) and B takes `mem_rdata`. The index then holds its old value plus two, modulo 2^16.
- R5: Sub-codes 011001 (X) and 011011 (Y) store BA. They write A at the index in the first cycle and B at the index plus one in the second, with `mem_we` high in both cycles. Prefix 00001 stores immediate bits 3..0 at X, then bits 7..4 at X+1. Each of these stores then advances the index by two. `mem_rd` and `mem_we` are never high together.
- R6: Sub-codes 01000x / 01001x add the zero-extended BA to X / Y. Prefixes 01100 / 01101 add bits 7..0 sign-extended (-128..127) to X / Y. C takes the carry out of bit 15 and Z is left unchanged.
- R7: Prefixes 01110 (X) and 01111 (Y) compare the low byte of the index with k = FFh minus bits 7..0. C becomes 1 when the low byte is below k (unsigned), and Z becomes 1 when the two are equal. No register changes.
- R8: Sub-codes 101000 / 101100 increment SP1 / SP2, and 100000 / 100100 decrement them, wrapping modulo 256.
- R9: E becomes 1 after any load of EXT (immediate or from BA) and 0 after every other accepted instruction.
- R10: `busy` is high for exactly the one cycle following the first cycle of a memory transfer. An instruction presented in that cycle has no effect.
- R11: A word outside the encodings above, or any cycle without `instr_valid`, changes no register or flag and drives no memory strobe.
- R12: C and Z change only through R6 (C only) and R7. All moves, loads, stores and stack pointer steps leave them as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | An instruction word is presented this cycle |
| instr | input | 13 | Instruction word |
| mem_rdata | input | 4 | Nibble read from `mem_addr` in the same cycle |
| mem_addr | output | 16 | Nibble memory address |
| mem_rd | output | 1 | Read strobe |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 4 | Nibble to write |
| busy | output | 1 | Second cycle of a memory transfer in progress |
| reg_a | output | 4 | A (low nibble of BA) |
| reg_b | output | 4 | B (high nibble of BA) |
| idx_x | output | 16 | Index register X |
| idx_y | output | 16 | Index register Y |
| ext_q | output | 8 | Extension register |
| sp1_q | output | SP_W (8) | Stack pointer 1 |
| sp2_q | output | SP_W (8) | Stack pointer 2 |
| flag_c | output | 1 | Carry / borrow flag |
| flag_z | output | 1 | Zero / equal flag |
| flag_e | output | 1 | Extension flag |

## Verification
Every register of the unit is a port, so a wrong update to BA, an index, EXT or a stack pointer shows one clock after the instruction that caused it. A wrong pending-transfer state (wrong direction, wrong index, lost high immediate nibble) shows in the second cycle as a wrong address, strobe or write nibble, and one clock later as a wrong B or wrong index advance. A decode slip that touches C, Z or E on a plain move shows at the flag ports on the next edge. Compare results are checked on both sides of the equality and across the borrow boundary, because only the flags carry them.

// File: rtl/bxu_pkg.sv
package bxu_pkg;

  localparam int INSTR_W = 13;
  localparam int NIB_W   = 4;
  localparam int BYTE_W  = 2 * NIB_W;
  localparam int IDX_W   = 2 * BYTE_W;
  localparam int PFX_W   = 5;
  localparam int SUB_W   = 6;

  typedef enum logic [2:0] {
    BA_FROM_IMM, BA_FROM_XL, BA_FROM_XH, BA_FROM_YL,
    BA_FROM_YH,  BA_FROM_EXT, BA_FROM_SP1, BA_FROM_SP2
  } ba_src_e;

  typedef enum logic [1:0] {SP_HOLD, SP_LOAD, SP_INC, SP_DEC} sp_op_e;

  typedef enum logic [1:0] {MEM_NONE, MEM_LOAD, MEM_STORE, MEM_STORE_IMM} mem_op_e;

  typedef struct packed {
    logic              legal;
    logic              ba_we;
    ba_src_e           ba_src;
    logic [3:0]        half_we;   // {YH, YL, XH, XL}
    logic              half_imm;
    logic              ext_we;
    logic              ext_imm;
    sp_op_e            sp1_op;
    sp_op_e            sp2_op;
    logic              add_en;
    logic              add_imm;
    logic              cmp_en;
    logic              use_y;
    mem_op_e           mem_op;
    logic [BYTE_W-1:0] imm;
  } dec_t;

endpackage

// File: rtl/bxu_decode.sv
module bxu_decode
  import bxu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);

  logic [PFX_W-1:0] pfx;
  logic [SUB_W-1:0] sub;

  assign pfx = instr[INSTR_W-1 -: PFX_W];
  assign sub = instr[SUB_W-1:0];

  always_comb begin
    dec         = '0;
    dec.ba_src  = BA_FROM_IMM;
    dec.sp1_op  = SP_HOLD;
    dec.sp2_op  = SP_HOLD;
    dec.mem_op  = MEM_NONE;
    dec.imm     = instr[BYTE_W-1:0];
    unique case (pfx)
      5'b01001: begin dec.legal = 1'b1; dec.ba_we = 1'b1; dec.ba_src = BA_FROM_IMM; end
      5'b01010: begin dec.legal = 1'b1; dec.half_we = 4'b0001; dec.half_imm = 1'b1; end
      5'b01011: begin dec.legal = 1'b1; dec.half_we = 4'b0100; dec.half_imm = 1'b1; end
      5'b01000: begin dec.legal = 1'b1; dec.ext_we = 1'b1; dec.ext_imm = 1'b1; end
      5'b00001: begin dec.legal = 1'b1; dec.mem_op = MEM_STORE_IMM; end
      5'b01100: begin dec.legal = 1'b1; dec.add_en = 1'b1; dec.add_imm = 1'b1; end
      5'b01101: begin dec.legal = 1'b1; dec.add_en = 1'b1; dec.add_imm = 1'b1; dec.use_y = 1'b1; end
      5'b01110: begin dec.legal = 1'b1; dec.cmp_en = 1'b1; end
      5'b01111: begin dec.legal = 1'b1; dec.cmp_en = 1'b1; dec.use_y = 1'b1; end
      5'b11111: begin
        if (instr[7:6] == 2'b11) begin
          dec.legal = 1'b1;
          casez (sub)
            6'b0000??: dec.half_we = 4'b0001 << sub[1:0];
            6'b00010?: dec.sp1_op = SP_LOAD;
            6'b00011?: dec.sp2_op = SP_LOAD;
            6'b0010??: begin
              dec.ba_we  = 1'b1;
              dec.ba_src = ba_src_e'({1'b0, sub[1:0]} + 3'd1);
            end
            6'b00110?: begin dec.ba_we = 1'b1; dec.ba_src = BA_FROM_SP1; end
            6'b00111?: begin dec.ba_we = 1'b1; dec.ba_src = BA_FROM_SP2; end
            6'b01000?: dec.add_en = 1'b1;
            6'b01001?: begin dec.add_en = 1'b1; dec.use_y = 1'b1; end
            6'b01010?: dec.ext_we = 1'b1;
            6'b01011?: begin dec.ba_we = 1'b1; dec.ba_src = BA_FROM_EXT; end
            6'b011000: dec.mem_op = MEM_LOAD;
            6'b011001: dec.mem_op = MEM_STORE;
            6'b011010: begin dec.mem_op = MEM_LOAD;  dec.use_y = 1'b1; end
            6'b011011: begin dec.mem_op = MEM_STORE; dec.use_y = 1'b1; end
            6'b100000: dec.sp1_op = SP_DEC;
            6'b100100: dec.sp2_op = SP_DEC;
            6'b101000: dec.sp1_op = SP_INC;
            6'b101100: dec.sp2_op = SP_INC;
            default:   dec.legal = 1'b0;
          endcase
        end
      end
      default: dec.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/bxu_index_alu.sv
module bxu_index_alu
  import bxu_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              is_signed,
  input  logic [BYTE_W-1:0] cmp_field,
  output logic [IDX_W-1:0]  sum,
  output logic              carry,
  output logic              cmp_borrow,
  output logic              cmp_equal
);

  localparam int EXT_W = IDX_W - BYTE_W;

  logic [IDX_W-1:0]  operand;
  logic [BYTE_W-1:0] cmp_val;
  logic [BYTE_W:0]   diff;

  always_comb begin
    operand      = {{EXT_W{is_signed & byte_val[BYTE_W-1]}}, byte_val};
    {carry, sum} = {1'b0, idx} + {1'b0, operand};
    cmp_val      = ~cmp_field;
    diff         = {1'b0, idx[BYTE_W-1:0]} - {1'b0, cmp_val};
    cmp_borrow   = diff[BYTE_W];
    cmp_equal    = (idx[BYTE_W-1:0] == cmp_val);
  end

endmodule

// File: rtl/bxu_sp_reg.sv
module bxu_sp_reg
  import bxu_pkg::*;
#(
  parameter int SP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sp_op_e            op,
  input  logic [BYTE_W-1:0] ba,
  output logic [SP_W-1:0]   q
);

  logic [SP_W-1:0] q_n;
  logic            q_en;

  always_comb begin
    q_n  = q;
    q_en = 1'b1;
    unique case (op)
      SP_LOAD: q_n = SP_W'(ba);
      SP_INC:  q_n = q + SP_W'(1);
      SP_DEC:  q_n = q - SP_W'(1);
      default: q_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_n;
  end

endmodule

// File: rtl/byte_xfer_unit.sv
module byte_xfer_unit
  import bxu_pkg::*;
#(
  parameter int SP_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [NIB_W-1:0]   mem_rdata,
  output logic [IDX_W-1:0]   mem_addr,
  output logic               mem_rd,
  output logic               mem_we,
  output logic [NIB_W-1:0]   mem_wdata,
  output logic               busy,
  output logic [NIB_W-1:0]   reg_a,
  output logic [NIB_W-1:0]   reg_b,
  output logic [IDX_W-1:0]   idx_x,
  output logic [IDX_W-1:0]   idx_y,
  output logic [BYTE_W-1:0]  ext_q,
  output logic [SP_W-1:0]    sp1_q,
  output logic [SP_W-1:0]    sp2_q,
  output logic               flag_c,
  output logic               flag_z,
  output logic               flag_e
);

  localparam int NUM_SP = 2;

  dec_t dec;
  logic accept;

  // state registers
  logic [NIB_W-1:0]  a_q, b_q;
  logic [IDX_W-1:0]  x_q, y_q;
  logic [BYTE_W-1:0] ext_r;
  logic              c_q, z_q, e_q, busy_q;
  mem_op_e           pend_op_q;
  logic              pend_y_q;
  logic [NIB_W-1:0]  pend_hi_q;

  // next-state and enables
  logic [NIB_W-1:0]  a_n, b_n;
  logic [IDX_W-1:0]  x_n, y_n;
  logic [BYTE_W-1:0] ext_n;
  logic              c_n, z_n, e_n, busy_n;
  mem_op_e           pend_op_n;
  logic              pend_y_n;
  logic [NIB_W-1:0]  pend_hi_n;
  logic              a_en, b_en, x_en, y_en, ext_en, c_en, z_en, e_en, pend_en;

  logic [BYTE_W-1:0] ba_val, ba_sel, half_src;
  logic [IDX_W-1:0]  alu_idx, alu_sum, cur_idx;
  logic              alu_carry, alu_borrow, alu_equal;

  logic [NUM_SP-1:0][SP_W-1:0] sp_q;
  sp_op_e                      sp_op [NUM_SP];

  bxu_decode u_decode (
    .instr (instr),
    .dec   (dec)
  );

  assign accept  = instr_valid && !busy_q && dec.legal;
  assign ba_val  = {b_q, a_q};
  assign alu_idx = dec.use_y ? y_q : x_q;

  bxu_index_alu u_alu (
    .idx        (alu_idx),
    .byte_val   (dec.add_imm ? dec.imm : ba_val),
    .is_signed  (dec.add_imm),
    .cmp_field  (dec.imm),
    .sum        (alu_sum),
    .carry      (alu_carry),
    .cmp_borrow (alu_borrow),
    .cmp_equal  (alu_equal)
  );

  // stack pointers: one register slice per pointer
  assign sp_op[0] = accept ? dec.sp1_op : SP_HOLD;
  assign sp_op[1] = accept ? dec.sp2_op : SP_HOLD;

  for (genvar gi = 0; gi < NUM_SP; gi++) begin : g_sp
    bxu_sp_reg #(.SP_W(SP_W)) u_sp (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (sp_op[gi]),
      .ba    (ba_val),
      .q     (sp_q[gi])
    );
  end

  // byte source for loads into BA
  always_comb begin
    unique case (dec.ba_src)
      BA_FROM_XL:  ba_sel = x_q[BYTE_W-1:0];
      BA_FROM_XH:  ba_sel = x_q[IDX_W-1:BYTE_W];
      BA_FROM_YL:  ba_sel = y_q[BYTE_W-1:0];
      BA_FROM_YH:  ba_sel = y_q[IDX_W-1:BYTE_W];
      BA_FROM_EXT: ba_sel = ext_r;
      BA_FROM_SP1: ba_sel = sp_q[0][BYTE_W-1:0];
      BA_FROM_SP2: ba_sel = sp_q[1][BYTE_W-1:0];
      default:     ba_sel = dec.imm;
    endcase
  end

  assign half_src = dec.half_imm ? dec.imm : ba_val;

  // memory port: first cycle at index, second at index + 1
  always_comb begin
    cur_idx   = busy_q ? (pend_y_q ? y_q : x_q) : alu_idx;
    mem_addr  = busy_q ? cur_idx + IDX_W'(1) : cur_idx;
    mem_rd    = 1'b0;
    mem_we    = 1'b0;
    mem_wdata = a_q;
    if (busy_q) begin
      mem_rd    = (pend_op_q == MEM_LOAD);
      mem_we    = (pend_op_q == MEM_STORE) || (pend_op_q == MEM_STORE_IMM);
      mem_wdata = (pend_op_q == MEM_STORE_IMM) ? pend_hi_q : b_q;
    end else if (accept) begin
      mem_rd    = (dec.mem_op == MEM_LOAD);
      mem_we    = (dec.mem_op == MEM_STORE) || (dec.mem_op == MEM_STORE_IMM);
      mem_wdata = (dec.mem_op == MEM_STORE_IMM) ? dec.imm[NIB_W-1:0] : a_q;
    end
  end

  // next-state logic
  always_comb begin
    a_n = a_q;   b_n = b_q;   x_n = x_q;   y_n = y_q;   ext_n = ext_r;
    c_n = c_q;   z_n = z_q;   e_n = e_q;
    pend_op_n = pend_op_q;  pend_y_n = pend_y_q;  pend_hi_n = pend_hi_q;
    a_en = 1'b0; b_en = 1'b0; x_en = 1'b0; y_en = 1'b0; ext_en = 1'b0;
    c_en = 1'b0; z_en = 1'b0; e_en = 1'b0; pend_en = 1'b0;
    busy_n = 1'b0;

    if (busy_q) begin
      if (pend_op_q == MEM_LOAD) begin
        b_n  = mem_rdata;
        b_en = 1'b1;
      end
      if (pend_y_q) begin
        y_n  = y_q + IDX_W'(2);
        y_en = 1'b1;
      end else begin
        x_n  = x_q + IDX_W'(2);
        x_en = 1'b1;
      end
    end else if (accept) begin
      e_n  = dec.ext_we;
      e_en = 1'b1;

      if (dec.ba_we) begin
        {b_n, a_n} = ba_sel;
        a_en = 1'b1;
        b_en = 1'b1;
      end

      if (dec.half_we[0]) x_n[BYTE_W-1:0]     = half_src;
      if (dec.half_we[1]) x_n[IDX_W-1:BYTE_W] = half_src;
      if (dec.half_we[2]) y_n[BYTE_W-1:0]     = half_src;
      if (dec.half_we[3]) y_n[IDX_W-1:BYTE_W] = half_src;
      x_en = |dec.half_we[1:0];
      y_en = |dec.half_we[3:2];

      if (dec.ext_we) begin
        ext_n  = dec.ext_imm ? dec.imm : ba_val;
        ext_en = 1'b1;
      end

      if (dec.add_en) begin
        if (dec.use_y) begin
          y_n  = alu_sum;
          y_en = 1'b1;
        end else begin
          x_n  = alu_sum;
          x_en = 1'b1;
        end
        c_n  = alu_carry;
        c_en = 1'b1;
      end

      if (dec.cmp_en) begin
        c_n  = alu_borrow;
        z_n  = alu_equal;
        c_en = 1'b1;
        z_en = 1'b1;
      end

      if (dec.mem_op != MEM_NONE) begin
        busy_n    = 1'b1;
        pend_op_n = dec.mem_op;
        pend_y_n  = dec.use_y;
        pend_hi_n = dec.imm[BYTE_W-1:NIB_W];
        pend_en   = 1'b1;
        if (dec.mem_op == MEM_LOAD) begin
          a_n  = mem_rdata;
          a_en = 1'b1;
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q       <= '0;
      b_q       <= '0;
      x_q       <= '0;
      y_q       <= '0;
      ext_r     <= '0;
      c_q       <= 1'b0;
      z_q       <= 1'b0;
      e_q       <= 1'b0;
      busy_q    <= 1'b0;
      pend_op_q <= MEM_NONE;
      pend_y_q  <= 1'b0;
      pend_hi_q <= '0;
    end else begin
      busy_q <= busy_n;
      if (a_en)   a_q   <= a_n;
      if (b_en)   b_q   <= b_n;
      if (x_en)   x_q   <= x_n;
      if (y_en)   y_q   <= y_n;
      if (ext_en) ext_r <= ext_n;
      if (c_en)   c_q   <= c_n;
      if (z_en)   z_q   <= z_n;
      if (e_en)   e_q   <= e_n;
      if (pend_en) begin
        pend_op_q <= pend_op_n;
        pend_y_q  <= pend_y_n;
        pend_hi_q <= pend_hi_n;
      end
    end
  end

  assign busy   = busy_q;
  assign reg_a  = a_q;
  assign reg_b  = b_q;
  assign idx_x  = x_q;
  assign idx_y  = y_q;
  assign ext_q  = ext_r;
  assign sp1_q  = sp_q[0];
  assign sp2_q  = sp_q[1];
  assign flag_c = c_q;
  assign flag_z = z_q;
  assign flag_e = e_q;

endmodule

// File: rtl/bxu_chk.sv
module bxu_chk
  import bxu_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             instr_valid,
  input logic             busy,
  input logic             mem_rd,
  input logic             mem_we,
  input logic [IDX_W-1:0] mem_addr,
  input logic [IDX_W-1:0] idx_x,
  input logic [IDX_W-1:0] idx_y,
  input logic             flag_e
);

  p_busy_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  p_second_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mem_addr == IDX_W'($past(mem_addr) + IDX_W'(1))));

  p_busy_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mem_rd || mem_we));

  p_index_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ((idx_x == IDX_W'($past(idx_x) + IDX_W'(2))) ||
                     (idx_y == IDX_W'($past(idx_y) + IDX_W'(2)))));

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_we));

  p_e_clear_in_xfer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !flag_e);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr_valid && !busy) |-> !(mem_rd || mem_we));

endmodule

bind byte_xfer_unit bxu_chk u_bxu_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .busy        (busy),
  .mem_rd      (mem_rd),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .idx_x       (idx_x),
  .idx_y       (idx_y),
  .flag_e      (flag_e)
);

// File: tb/test_byte_xfer_unit.sv
`timescale 1ns/1ps
module test_byte_xfer_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid;
  logic [12:0] instr;
  logic [3:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_we;
  logic [3:0]  mem_wdata;
  logic        busy;
  logic [3:0]  reg_a, reg_b;
  logic [15:0] idx_x, idx_y;
  logic [7:0]  ext_q, sp1_q, sp2_q;
  logic        flag_c, flag_z, flag_e;

  int checks = 0;
  int errors = 0;

  logic [3:0] mem [256];

  // reference state
  logic [3:0]  ma, mb;
  logic [15:0] mx, my;
  logic [7:0]  mext, msp1, msp2;
  logic        mc, mz, me, mbusy, mpy;
  int          mpk;   // 0 none, 1 load, 2 store BA, 3 store immediate
  logic [3:0]  mphi;

  always #5 clk = ~clk;

  assign mem_rdata = mem[mem_addr[7:0]];

  byte_xfer_unit i_byte_xfer_unit (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .busy(busy), .reg_a(reg_a), .reg_b(reg_b),
    .idx_x(idx_x), .idx_y(idx_y), .ext_q(ext_q), .sp1_q(sp1_q), .sp2_q(sp2_q),
    .flag_c(flag_c), .flag_z(flag_z), .flag_e(flag_e)
  );

  function automatic logic [12:0] rop(input logic [5:0] s);
    return {7'b1111111, s};
  endfunction

  function automatic logic [12:0] iop(input logic [4:0] p, input logic [7:0] v);
    return {p, v};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    chk(reg_a == ma,     tag, "A",    reg_a, ma);
    chk(reg_b == mb,     tag, "B",    reg_b, mb);
    chk(idx_x == mx,     tag, "X",    idx_x, mx);
    chk(idx_y == my,     tag, "Y",    idx_y, my);
    chk(ext_q == mext,   tag, "EXT",  ext_q, mext);
    chk(sp1_q == msp1,   tag, "SP1",  sp1_q, msp1);
    chk(sp2_q == msp2,   tag, "SP2",  sp2_q, msp2);
    chk(flag_c == mc,    tag, "C",    flag_c, mc);
    chk(flag_z == mz,    tag, "Z",    flag_z, mz);
    chk(flag_e == me,    tag, "E",    flag_e, me);
    chk(busy == mbusy,   tag, "busy", busy, mbusy);
  endtask

  // one clock of stimulus with the reference model stepped alongside
  task automatic step(input logic v, input logic [12:0] ins, input string tag);
    logic        e_rd, e_we;
    logic [15:0] e_addr;
    logic [3:0]  e_wd;
    logic [3:0]  na, nb;
    logic [15:0] nx, ny, base;
    logic [7:0]  next_ext, ns1, ns2, k, iv;
    logic        nc, nz, ne, nbusy, legal;
    logic [16:0] wide;
    logic [4:0]  p;
    logic [5:0]  s;
    @(negedge clk);
    instr_valid = v;
    instr       = ins;
    #1;
    e_rd = 0; e_we = 0; e_addr = 16'h0; e_wd = 4'h0;
    na = ma; nb = mb; nx = mx; ny = my; next_ext = mext; ns1 = msp1; ns2 = msp2;
    nc = mc; nz = mz; ne = me; nbusy = 0;
    p = ins[12:8]; s = ins[5:0]; iv = ins[7:0];
    if (mbusy) begin
      base   = mpy ? my : mx;
      e_addr = base + 16'd1;
      if (mpk == 1) begin e_rd = 1; nb = mem[e_addr[7:0]]; end
      else begin e_we = 1; e_wd = (mpk == 3) ? mphi : mb; end
      if (mpy) ny = my + 16'd2; else nx = mx + 16'd2;
    end else if (v) begin
      legal = 1;
      if (p == 5'b01001) {nb, na} = iv;
      else if (p == 5'b01010) nx[7:0] = iv;
      else if (p == 5'b01011) ny[7:0] = iv;
      else if (p == 5'b01000) next_ext = iv;
      else if (p == 5'b00001) begin
        e_we = 1; e_addr = mx; e_wd = iv[3:0]; nbusy = 1; mpk = 3; mpy = 0; mphi = iv[7:4];
      end else if (p == 5'b01100 || p == 5'b01101) begin
        wide = {1'b0, (p[0] ? my : mx)} + {1'b0, {8{iv[7]}}, iv};
        if (p[0]) ny = wide[15:0]; else nx = wide[15:0];
        nc = wide[16];
      end else if (p == 5'b01110 || p == 5'b01111) begin
        k  = 8'hFF - iv;
        base = p[0] ? my : mx;
        nc = (base[7:0] < k);
        nz = (base[7:0] == k);
      end else if (p == 5'b11111 && ins[7:6] == 2'b11) begin
        if (s[5:2] == 4'b0000) begin
          if (s[1:0] == 0) nx[7:0] = {mb, ma};
          else if (s[1:0] == 1) nx[15:8] = {mb, ma};
          else if (s[1:0] == 2) ny[7:0] = {mb, ma};
          else ny[15:8] = {mb, ma};
        end else if (s[5:2] == 4'b0010) begin
          if (s[1:0] == 0) {nb, na} = mx[7:0];
          else if (s[1:0] == 1) {nb, na} = mx[15:8];
          else if (s[1:0] == 2) {nb, na} = my[7:0];
          else {nb, na} = my[15:8];
        end else if (s[5:1] == 5'b00010) ns1 = {mb, ma};
        else if (s[5:1] == 5'b00011) ns2 = {mb, ma};
        else if (s[5:1] == 5'b00110) {nb, na} = msp1;
        else if (s[5:1] == 5'b00111) {nb, na} = msp2;
        else if (s[5:1] == 5'b01000 || s[5:1] == 5'b01001) begin
          wide = {1'b0, (s[1] ? my : mx)} + {9'b0, mb, ma};
          if (s[1]) ny = wide[15:0]; else nx = wide[15:0];
          nc = wide[16];
        end else if (s[5:1] == 5'b01010) next_ext = {mb, ma};
        else if (s[5:1] == 5'b01011) {nb, na} = mext;
        else if (s[5:2] == 4'b0110) begin
          mpy = s[1]; nbusy = 1; e_addr = s[1] ? my : mx;
          if (!s[0]) begin mpk = 1; e_rd = 1; na = mem[e_addr[7:0]]; end
          else begin mpk = 2; e_we = 1; e_wd = ma; end
        end else if (s == 6'b101000) ns1 = msp1 + 8'd1;
        else if (s == 6'b100000) ns1 = msp1 - 8'd1;
        else if (s == 6'b101100) ns2 = msp2 + 8'd1;
        else if (s == 6'b100100) ns2 = msp2 - 8'd1;
        else legal = 0;
      end else legal = 0;
      if (legal) ne = (p == 5'b01000) || (p == 5'b11111 && s[5:1] == 5'b01010);
    end
    chk(mem_rd == e_rd, tag, "mem_rd", mem_rd, e_rd);
    chk(mem_we == e_we, tag, "mem_we", mem_we, e_we);
    if (e_rd || e_we) chk(mem_addr == e_addr, tag, "mem_addr", mem_addr, e_addr);
    if (e_we) chk(mem_wdata == e_wd, tag, "mem_wdata", mem_wdata, e_wd);
    @(posedge clk);
    if (e_we) mem[e_addr[7:0]] = e_wd;
    ma = na; mb = nb; mx = nx; my = ny; mext = next_ext; msp1 = ns1; msp2 = ns2;
    mc = nc; mz = nz; me = ne; mbusy = nbusy;
    #1;
    check_state(tag);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 4'((i * 7 + 3) % 16);
    ma = 0; mb = 0; mx = 0; my = 0; mext = 0; msp1 = 0; msp2 = 0;
    mc = 0; mz = 0; me = 0; mbusy = 0; mpy = 0; mpk = 0; mphi = 0;
    rst_n = 1'b0; instr_valid = 1'b0; instr = '0;
    repeat (3) @(posedge clk);
    #1;
    check_state("R1");
    chk(!mem_rd && !mem_we, "R1", "strobes", {mem_rd, mem_we}, 0);
    @(negedge clk); rst_n = 1'b1;
    step(0, '0, "R1");

    // immediate loads and E behaviour
    step(1, iop(5'b01001, 8'h5A), "R3");
    step(1, iop(5'b01010, 8'hF0), "R3");
    step(1, iop(5'b01011, 8'h10), "R3");
    step(1, iop(5'b01000, 8'h3C), "R9");          // E set
    step(1, 13'b1111110000000, "R11");             // illegal: E held
    step(1, iop(5'b10000, 8'hAA), "R11");          // illegal prefix
    step(0, rop(6'b001000), "R11");                // not valid
    step(1, rop(6'b000001), "R2");                 // XH <- BA, E cleared
    step(1, rop(6'b000011), "R2");                 // YH <- BA
    step(1, rop(6'b001000), "R2");                 // BA <- XL
    step(1, rop(6'b001011), "R2");                 // BA <- YH
    step(1, rop(6'b010110), "R2");                 // BA <- EXT
    step(1, rop(6'b010100), "R9");                 // EXT <- BA sets E
    step(1, rop(6'b000100), "R2");                 // SP1 <- BA

    // stack pointers and wrap
    step(1, iop(5'b01001, 8'hFF), "R3");
    step(1, rop(6'b000110), "R2");                 // SP2 <- FF
    step(1, rop(6'b101100), "R8");                 // SP2 wraps to 00
    step(1, rop(6'b100100), "R8");                 // SP2 back to FF
    step(1, rop(6'b101000), "R8");
    step(1, iop(5'b01001, 8'h00), "R3");
    step(1, rop(6'b000100), "R2");                 // SP1 <- 00
    step(1, rop(6'b100000), "R8");                 // SP1 wraps to FF
    step(1, rop(6'b001100), "R2");                 // BA <- SP1
    step(1, rop(6'b001110), "R2");                 // BA <- SP2

    // index arithmetic
    step(1, iop(5'b01001, 8'hC3), "R3");
    step(1, rop(6'b010000), "R6");                 // X += BA
    step(1, rop(6'b010010), "R6");                 // Y += BA
    step(1, iop(5'b01100, 8'h80), "R6");           // X += -128
    step(1, iop(5'b01101, 8'h7F), "R6");           // Y += 127
    step(1, iop(5'b01100, 8'hFF), "R6");           // X += -1
    step(1, iop(5'b01010, 8'hFF), "R3");
    step(1, iop(5'b01001, 8'hFF), "R3");
    step(1, rop(6'b000001), "R2");                 // X = FFFF
    step(1, iop(5'b01100, 8'h01), "R6");           // carry out, X = 0000

    // compare: field = FF - k
    step(1, iop(5'b01010, 8'h40), "R3");
    step(1, iop(5'b01110, 8'hFF - 8'h40), "R7");   // equal
    step(1, iop(5'b01110, 8'hFF - 8'h41), "R7");   // borrow
    step(1, iop(5'b01110, 8'hFF - 8'h3F), "R7");   // above
    step(1, iop(5'b01011, 8'h00), "R3");
    step(1, iop(5'b01111, 8'hFF), "R7");           // Y low 00 vs 00
    step(1, iop(5'b01111, 8'h00), "R7");           // 00 vs FF borrow
    step(1, rop(6'b000000), "R12");                // flags held on move

    // memory transfers
    step(1, iop(5'b01010, 8'h10), "R3");
    step(1, iop(5'b01001, 8'h00), "R3");
    step(1, rop(6'b000001), "R2");                 // X = 0010
    step(1, rop(6'b011000), "R4");                 // BA <- [X]+
    step(0, '0, "R4");
    step(1, iop(5'b01011, 8'h20), "R3");
    step(1, rop(6'b000011), "R2");                 // Y = BA:20
    step(1, rop(6'b011011), "R5");                 // [Y]+ <- BA
    step(1, iop(5'b01001, 8'h99), "R10");          // ignored while busy
    step(1, iop(5'b00001, 8'hD6), "R5");           // immediate store
    step(0, '0, "R5");
    step(1, iop(5'b01100, 8'hFE), "R6");           // X -= 2
    step(1, rop(6'b011000), "R4");                 // read back
    step(1, rop(6'b101000), "R10");                // ignored while busy
    step(1, iop(5'b01000, 8'h11), "R9");
    step(1, rop(6'b011010), "R9");                 // mem op clears E
    step(0, '0, "R4");
    step(1, iop(5'b01001, 8'hFF), "R3");
    step(1, iop(5'b01010, 8'hFF), "R3");
    step(1, rop(6'b000001), "R2");                 // X = FFFF
    step(1, rop(6'b011000), "R4");                 // address wraps
    step(0, '0, "R4");
    step(1, rop(6'b011001), "R5");                 // store through X
    step(0, '0, "R5");
    step(0, '0, "R11");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule